// File: doc/BRIEF.md
# Park and Power-Enable Sequencer

This block sequences power for a micromirror display controller. An active-low park request and a reset pin come in. A regulator enable, an output-enable flag for that regulator pin, a host-bus ready flag and a 7-bit I2C target address go out. When park is released (driven high), the regulator enable turns on. When park is asserted again (driven low), the enable stays on for a programmable hold time before it turns off. This gives the mirrors time to settle before their supplies collapse.

The host-bus ready flag marks the end of a quiet period. The host must not touch the control bus until park and reset have both been high for a programmable number of milliseconds. The I2C target address is taken from a strap pin on the first clock edge after reset is released, and it then holds until the next reset. The hold time is given in microseconds and the quiet time in milliseconds. The block turns both into clock-cycle terminal counts using a clock-frequency parameter. The I2C engine, the regulators and the mirror data path are outside this block.

Top module: `park_power_seq`

## Requirements
- R1: While `rst_n` is low, `reg_en`, `reg_oe` and `host_ready` are all 0.
- R2: `reg_oe` goes to 1 at the first rising clock edge after `rst_n` goes high, and stays 1 until the next reset.
- R3: At that same first edge, `i2c_addr` takes the value 0x1B if `addr_strap` is 0, or 0x1D if `addr_strap` is 1.
- R4: Changes on `addr_strap` after the capture edge have no effect on `i2c_addr` until the next reset.
- R5: `park_n` passes through a SYNC_STAGES-deep synchronizer (2 by default). `reg_en` rises at the third clock edge after `park_n` rises, and it stays 1 while `park_n` stays high.
- R6: After `park_n` falls, `reg_en` stays 1 for HOLD_CYC = CLK_FREQ_HZ/1e6 * HOLD_US cycles. It goes to 0 at edge HOLD_CYC+3 after the fall.
- R7: If `park_n` rises again before the hold window ends, the hold is cancelled and `reg_en` never drops. A later fall starts a fresh, full hold window.
- R8: `host_ready` rises at edge QUIET_CYC+2 after `park_n` rises while reset is released, where QUIET_CYC = CLK_FREQ_HZ/1e3 * QUIET_MS.
- R9: `host_ready` falls at the second edge after `park_n` falls. When park rises again, the full quiet count starts over from zero.
- R10: Asserting `rst_n` in the middle of operation clears all outputs at once. After release, the strap is sampled again, and both the enable delay and the quiet count restart from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Reset, active low. Asserts asynchronously; release is assumed to be synchronous to `clk` |
| park_n | input | 1 | Park request, active low. High means normal operation. Asynchronous |
| addr_strap | input | 1 | Strap that selects the I2C target address at reset release |
| reg_en | output | 1 | Regulator enable, active high |
| reg_oe | output | 1 | Output-enable flag for `reg_en`. 0 means the pin is meant to be tristated |
| host_ready | output | 1 | Host control-bus access allowed |
| i2c_addr | output | 7 | Selected 7-bit I2C target address |

## Verification
The assertions rely on three properties of the inputs. `rst_n` is released in step with the clock. `addr_strap` is steady around the edge that releases reset. `park_n` may move at any cycle, because it is resynchronized inside the block. The cycle-run counters in the checker count how long `park_n` has been sampled at one level, so the hold and quiet windows are checked without deep history. The stimulus changes inputs only on the falling clock edge. It keeps the strap fixed across every reset release and moves it only after the capture edge has passed. It also re-raises park in the middle of a hold window, well before the terminal count, so that the cancellation path is exercised.

// File: rtl/park_seq_pkg.sv
package park_seq_pkg;

  typedef enum logic [1:0] {
    PWR_OFF  = 2'd0,
    PWR_ON   = 2'd1,
    PWR_HOLD = 2'd2
  } pwr_state_e;

  localparam logic [6:0] TARGET_ADDR_LO = 7'h1B;
  localparam logic [6:0] TARGET_ADDR_HI = 7'h1D;

  // Cycles in (amount / per_sec) seconds at freq_hz, never below one.
  function automatic int unsigned cycles_for(input int unsigned freq_hz,
                                             input int unsigned amount,
                                             input int unsigned per_sec);
    longint unsigned prod;
    prod = longint'(freq_hz) * longint'(amount) / longint'(per_sec);
    if (prod == 0) return 1;
    return int'(prod);
  endfunction

  function automatic int unsigned count_width(input int unsigned terminal);
    if (terminal <= 1) return 1;
    return $clog2(terminal);
  endfunction

endpackage

// File: rtl/park_seq_sync.sv
module park_seq_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= {WIDTH{RST_VAL}};
        else        chain_q[0] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= {WIDTH{RST_VAL}};
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/park_seq_power_fsm.sv
module park_seq_power_fsm
  import park_seq_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 62500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic park_ok,
  output logic reg_en
);

  localparam int unsigned HW = count_width(HOLD_CYC);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

  pwr_state_e      state_q, state_d;
  logic [HW-1:0]   hold_q, hold_d;

  always_comb begin
    state_d = state_q;
    hold_d  = '0;
    case (state_q)
      PWR_OFF: begin
        if (park_ok) state_d = PWR_ON;
      end
      PWR_ON: begin
        if (!park_ok) state_d = PWR_HOLD;
      end
      PWR_HOLD: begin
        if (park_ok) begin
          state_d = PWR_ON;
        end else if (hold_q == HOLD_LAST) begin
          state_d = PWR_OFF;
        end else begin
          hold_d = hold_q + 1'b1;
        end
      end
      default: state_d = PWR_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWR_OFF;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
    end
  end

  assign reg_en = (state_q != PWR_OFF);

endmodule

// File: rtl/park_seq_quiet_timer.sv
module park_seq_quiet_timer
  import park_seq_pkg::*;
#(
  parameter int unsigned QUIET_CYC = 12500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic park_ok,
  output logic host_ready
);

  localparam int unsigned QW = count_width(QUIET_CYC);
  localparam logic [QW-1:0] QUIET_LAST = QW'(QUIET_CYC - 1);

  logic [QW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!park_ok) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == QUIET_LAST) done_q <= 1'b1;
      else                     cnt_q  <= cnt_q + 1'b1;
    end
  end

  // Drop at once when park is seen low; the counter clears next edge.
  assign host_ready = done_q & park_ok;

endmodule

// File: rtl/park_seq_addr_latch.sv
module park_seq_addr_latch
  import park_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap,
  output logic       captured,
  output logic [6:0] addr
);

  logic       cap_q;
  logic [6:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= 1'b0;
      addr_q <= TARGET_ADDR_LO;
    end else if (!cap_q) begin
      cap_q  <= 1'b1;
      addr_q <= strap ? TARGET_ADDR_HI : TARGET_ADDR_LO;
    end
  end

  assign captured = cap_q;
  assign addr     = addr_q;

endmodule

// File: rtl/park_power_seq.sv
module park_power_seq
  import park_seq_pkg::*;
#(
  parameter int unsigned CLK_FREQ_HZ = 125000000,
  parameter int unsigned HOLD_US     = 500,
  parameter int unsigned QUIET_MS    = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       park_n,
  input  logic       addr_strap,
  output logic       reg_en,
  output logic       reg_oe,
  output logic       host_ready,
  output logic [6:0] i2c_addr
);

  localparam int unsigned HOLD_CYC  = cycles_for(CLK_FREQ_HZ, HOLD_US, 1000000);
  localparam int unsigned QUIET_CYC = cycles_for(CLK_FREQ_HZ, QUIET_MS, 1000);

  logic park_ok;

  park_seq_sync #(
    .WIDTH  (1),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b0)
  ) u_park_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in (park_n),
    .d_out(park_ok)
  );

  park_seq_power_fsm #(
    .HOLD_CYC(HOLD_CYC)
  ) u_power (
    .clk    (clk),
    .rst_n  (rst_n),
    .park_ok(park_ok),
    .reg_en (reg_en)
  );

  park_seq_quiet_timer #(
    .QUIET_CYC(QUIET_CYC)
  ) u_quiet (
    .clk       (clk),
    .rst_n     (rst_n),
    .park_ok   (park_ok),
    .host_ready(host_ready)
  );

  park_seq_addr_latch u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap   (addr_strap),
    .captured(reg_oe),
    .addr    (i2c_addr)
  );

endmodule

// File: rtl/park_power_seq_chk.sv
module park_power_seq_chk #(
  parameter int unsigned HOLD_CYC    = 1,
  parameter int unsigned QUIET_CYC   = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       park_n,
  input logic       addr_strap,
  input logic       reg_en,
  input logic       reg_oe,
  input logic       host_ready,
  input logic [6:0] i2c_addr
);

  logic        seen_edge = 1'b0;
  logic [31:0] high_run;
  logic [31:0] low_run;

  always_ff @(posedge clk) seen_edge <= 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_run <= '0;
      low_run  <= '0;
    end else begin
      high_run <= !park_n ? '0 : ((&high_run) ? high_run : high_run + 1);
      low_run  <=  park_n ? '0 : ((&low_run)  ? low_run  : low_run + 1);
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    (seen_edge && !rst_n) |-> (!reg_en && !reg_oe && !host_ready));

  // R2
  oe_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> reg_oe);

  // R3
  addr_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_oe) |-> (i2c_addr == ($past(addr_strap) ? 7'h1D : 7'h1B)));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_oe && $past(reg_oe)) |-> $stable(i2c_addr));

  // R5
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_en) |-> (high_run >= SYNC_STAGES));

  // R5
  en_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (high_run >= SYNC_STAGES + 1) |-> reg_en);

  // R6
  hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_en) |-> (low_run >= HOLD_CYC));

  // R8
  quiet_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_ready) |-> (high_run >= QUIET_CYC));

  // R9
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!park_n && $past(!park_n)) |=> !host_ready);

endmodule

bind park_power_seq park_power_seq_chk #(
  .HOLD_CYC   (HOLD_CYC),
  .QUIET_CYC  (QUIET_CYC),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .park_n    (park_n),
  .addr_strap(addr_strap),
  .reg_en    (reg_en),
  .reg_oe    (reg_oe),
  .host_ready(host_ready),
  .i2c_addr  (i2c_addr)
);

// File: tb/park_power_seq_tb.sv
module park_power_seq_tb;

  localparam int unsigned FREQ  = 1000000;
  localparam int unsigned H_US  = 20;
  localparam int unsigned Q_MS  = 1;
  localparam int H = 20;    // FREQ/1e6 * H_US
  localparam int Q = 1000;  // FREQ/1e3 * Q_MS

  localparam int S_EN = 0, S_RDY = 1, S_OE = 2, S_ADDR = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       park_n = 1'b0;
  logic       addr_strap = 1'b1;
  logic       reg_en, reg_oe, host_ready;
  logic [6:0] i2c_addr;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    int    sig;
    int    val;
    string req;
  } exp_t;

  exp_t sb_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  park_power_seq #(
    .CLK_FREQ_HZ(FREQ),
    .HOLD_US    (H_US),
    .QUIET_MS   (Q_MS),
    .SYNC_STAGES(2)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .park_n    (park_n),
    .addr_strap(addr_strap),
    .reg_en    (reg_en),
    .reg_oe    (reg_oe),
    .host_ready(host_ready),
    .i2c_addr  (i2c_addr)
  );

  function automatic int read_sig(int s);
    case (s)
      S_EN:    return int'(reg_en);
      S_RDY:   return int'(host_ready);
      S_OE:    return int'(reg_oe);
      default: return int'(i2c_addr);
    endcase
  endfunction

  function automatic string sig_name(int s);
    case (s)
      S_EN:    return "reg_en";
      S_RDY:   return "host_ready";
      S_OE:    return "reg_oe";
      default: return "i2c_addr";
    endcase
  endfunction

  // Driver side: queue an expected value for a later cycle.
  task automatic expect_at(int at, int sig, int val, string req);
    sb_q.push_back('{at, sig, val, req});
  endtask

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Monitor: compare every queued item whose cycle has come.
  always @(negedge clk) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].at == cyc) begin
        checks++;
        if (read_sig(sb_q[i].sig) != sb_q[i].val) begin
          fails++;
          $display("FAIL %s %s cyc %0d actual %0h expected %0h", sb_q[i].req,
                   sig_name(sb_q[i].sig), cyc, read_sig(sb_q[i].sig), sb_q[i].val);
        end
        sb_q.delete(i);
      end
    end
  end

  initial begin
    int c;
    @(negedge clk);
    @(negedge clk);
    // R1: outputs idle under reset
    c = cyc;
    expect_at(c + 1, S_EN, 0, "R1");
    expect_at(c + 1, S_OE, 0, "R1");
    expect_at(c + 1, S_RDY, 0, "R1");
    wait_cyc(c + 2);

    // R2, R3: release with strap high
    c = cyc;
    rst_n = 1'b1;
    expect_at(c + 1, S_OE, 1, "R2");
    expect_at(c + 1, S_ADDR, 'h1D, "R3");
    wait_cyc(c + 1);
    addr_strap = 1'b0;
    expect_at(c + 5, S_ADDR, 'h1D, "R4");
    expect_at(c + 5, S_EN, 0, "R5");
    wait_cyc(c + 6);

    // R5, R8: park released
    c = cyc;
    park_n = 1'b1;
    expect_at(c + 2, S_EN, 0, "R5");
    expect_at(c + 3, S_EN, 1, "R5");
    expect_at(c + Q + 1, S_RDY, 0, "R8");
    expect_at(c + Q + 2, S_RDY, 1, "R8");
    expect_at(c + Q + 3, S_EN, 1, "R5");
    wait_cyc(c + Q + 5);

    // R6, R9: park asserted, hold then off
    c = cyc;
    park_n = 1'b0;
    expect_at(c + 1, S_RDY, 1, "R9");
    expect_at(c + 2, S_RDY, 0, "R9");
    expect_at(c + H + 2, S_EN, 1, "R6");
    expect_at(c + H + 3, S_EN, 0, "R6");
    wait_cyc(c + H + 5);

    // R7: cancel the hold, then a fresh full hold
    c = cyc;
    park_n = 1'b1;
    expect_at(c + Q + 2, S_RDY, 1, "R8");
    wait_cyc(c + Q + 5);
    c = cyc;
    park_n = 1'b0;
    for (int k = 1; k <= H + 10; k++) expect_at(c + k, S_EN, 1, "R7");
    expect_at(c + 3, S_RDY, 0, "R9");
    wait_cyc(c + 6);
    park_n = 1'b1;
    expect_at(c + 6 + Q + 1, S_RDY, 0, "R9");
    expect_at(c + 6 + Q + 2, S_RDY, 1, "R9");
    wait_cyc(c + 6 + Q + 5);
    c = cyc;
    park_n = 1'b0;
    expect_at(c + H + 2, S_EN, 1, "R7");
    expect_at(c + H + 3, S_EN, 0, "R7");
    wait_cyc(c + H + 6);

    // R10: reset in the middle of operation
    c = cyc;
    park_n = 1'b1;
    expect_at(c + 10, S_EN, 1, "R10");
    wait_cyc(c + 10);
    c = cyc;
    rst_n = 1'b0;
    addr_strap = 1'b0;
    expect_at(c + 1, S_EN, 0, "R10");
    expect_at(c + 1, S_OE, 0, "R10");
    expect_at(c + 1, S_RDY, 0, "R10");
    wait_cyc(c + 5);
    c = cyc;
    rst_n = 1'b1;
    expect_at(c + 1, S_OE, 1, "R10");
    expect_at(c + 1, S_ADDR, 'h1B, "R3");
    expect_at(c + 2, S_EN, 0, "R10");
    expect_at(c + 3, S_EN, 1, "R10");
    expect_at(c + Q + 1, S_RDY, 0, "R10");
    expect_at(c + Q + 2, S_RDY, 1, "R10");
    wait_cyc(c + 4);
    addr_strap = 1'b1;
    expect_at(c + 8, S_ADDR, 'h1B, "R4");
    wait_cyc(c + Q + 6);

    if (sb_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard R10 actual %0d pending expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule